// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block sits on the controller side of a system management bus. It sits between a requester and a byte-level I2C engine. A requester describes a whole transaction in one cycle: the protocol kind, the 7-bit target address, the command byte, a 16-bit word, and a block of up to `MAX_BLOCK` bytes with its length. The sequencer then expands that request into primitive bus operations and hands them to the engine one at a time. The primitives are start, repeated start, write a byte and sample the acknowledge, read a byte and answer ack or nack, and stop.

It has one state machine for the whole command set. Transactions that combine a write and a read switch direction with a repeated start. Block reads take their length from the first byte the target returns. Bytes read back are gathered into a result buffer with a count. Completion is signalled by a one-cycle `done` pulse, with an error flag and a code naming the phase that failed.

Top module: `smbus_txn_seq`

## Requirements
- R1: Every address byte is `{addr[6:0], dir}` with dir 1 for read and 0 for write. Operation codes on `opCode` are 0 start, 1 repeated start, 2 write, 3 read, 4 stop.
- R2: Quick command (proto 0 with dir 0, proto 1 with dir 1) issues start, the address byte, then stop, with no data byte.
- R3: Send byte (proto 2) is start, address write, `reqCmd` as the only byte, then stop. Receive byte (proto 3) is start, address read, one read answered nack, then stop. The result goes to `rdData[7:0]` and `rdCount` is 1.
- R4: Read byte (5) and read word (7) write the address and the command, then issue a repeated start and the address with read. They then read 1 or 2 bytes, acking all but the last, which gets nack, followed by stop. The first byte read lands in `rdData[7:0]`, so a word reads low byte first.
- R5: Write byte (4) sends command then `reqWord[7:0]`. Write word (6) sends command, `reqWord[7:0]`, `reqWord[15:8]`, then stop.
- R6: Process call (8) writes command, low and high word bytes, then makes a repeated-start read of two bytes (ack, nack) and issues stop.
- R7: Block write (9) sends command, `reqCount`, then `reqCount` bytes, byte i taken from `reqBlock[8i+7:8i]`, then stop.
- R8: Block read (10) reads a count byte with ack, then that many bytes. It acks all but the last and nacks the last. Byte i is stored in `rdData[8i+7:8i]`, and `rdCount` equals the count, at most `MAX_BLOCK`.
- R9: Block process call (11) writes a count of 1 to `MAX_BLOCK-1` and the bytes. It then makes a repeated-start read of a count byte and that many bytes.
- R10: A nack on any written byte is followed at once by stop, then `done` with `error`=1. `errPhase` is 1 for the first address, 2 for the command or send byte, 3 for the count or a data byte, and 4 for the read address.
- R11: A returned count of 0, or above the limit (`MAX_BLOCK` for block read, `MAX_BLOCK-1` for block process call), triggers one extra read answered nack and then stop. The transaction ends with `errPhase`=5 and `rdCount`=0.
- R12: A request with proto above 11, or a block write or block process call whose count is outside its range, performs no bus operation. It completes on the next cycle with `error`=1 and `errPhase`=6.
- R13: `done` is high for exactly one cycle. `busy` is high while a transaction runs. `reqStart` is ignored while busy.
- R14: `opValid` stays high, with `opCode`, `opData` and `opNack` unchanged, until the engine returns `opDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqStart | input | 1 | Start pulse for a new request |
| reqProto | input | 4 | Protocol kind, 0..11 |
| reqAddr | input | 7 | Target address |
| reqCmd | input | 8 | Command byte (byte to send for send byte) |
| reqWord | input | 16 | Word or single data byte to write |
| reqCount | input | 6 | Block write length |
| reqBlock | input | MAX_BLOCK*8 | Block write data, byte 0 in the low bits |
| busy | output | 1 | Transaction in progress |
| opValid | output | 1 | Primitive operation requested |
| opCode | output | 3 | Primitive operation kind |
| opData | output | 8 | Byte to write |
| opNack | output | 1 | Answer nack to this read |
| opDone | input | 1 | Engine finished the operation |
| rxNack | input | 1 | Target did not acknowledge a written byte |
| rxData | input | 8 | Byte read from the target |
| done | output | 1 | Transaction complete pulse |
| error | output | 1 | Last transaction failed |
| errPhase | output | 3 | Phase that failed |
| rdData | output | MAX_BLOCK*8 | Read-back buffer |
| rdCount | output | 6 | Number of valid bytes in rdData |

## Verification
Every protocol kind is driven with distinct addresses and data, so the op stream tells apart the address direction, byte order and where the repeated start falls. Block reads use returned counts of 4, the full 32, 31 in the process call, and the illegal values 0 and 32 (process call). These separate correct acking of the final byte from the error drain. Nacks are injected on the first address, a mid-word data byte and the read address, which checks that each failing phase gets its own code. Malformed requests and a second start issued mid-transaction show that neither reaches the bus.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  // protocol kinds
  localparam logic [3:0] P_QUICK_W  = 4'd0;
  localparam logic [3:0] P_QUICK_R  = 4'd1;
  localparam logic [3:0] P_SEND     = 4'd2;
  localparam logic [3:0] P_RECV     = 4'd3;
  localparam logic [3:0] P_WR_BYTE  = 4'd4;
  localparam logic [3:0] P_RD_BYTE  = 4'd5;
  localparam logic [3:0] P_WR_WORD  = 4'd6;
  localparam logic [3:0] P_RD_WORD  = 4'd7;
  localparam logic [3:0] P_PROC     = 4'd8;
  localparam logic [3:0] P_BLK_WR   = 4'd9;
  localparam logic [3:0] P_BLK_RD   = 4'd10;
  localparam logic [3:0] P_BLK_PROC = 4'd11;

  // primitive operations towards the byte engine
  localparam logic [2:0] OP_START  = 3'd0;
  localparam logic [2:0] OP_RSTART = 3'd1;
  localparam logic [2:0] OP_WRITE  = 3'd2;
  localparam logic [2:0] OP_READ   = 3'd3;
  localparam logic [2:0] OP_STOP   = 3'd4;

  // failing phase codes
  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_ADDR  = 3'd1;
  localparam logic [2:0] ERR_CMD   = 3'd2;
  localparam logic [2:0] ERR_DATA  = 3'd3;
  localparam logic [2:0] ERR_RADDR = 3'd4;
  localparam logic [2:0] ERR_COUNT = 3'd5;
  localparam logic [2:0] ERR_REQ   = 3'd6;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ADDR_W, SEL_ADDR_R, SEL_CMD, SEL_WCNT, SEL_WDATA
  } byte_sel_e;

  typedef struct packed {
    logic      latch;
    logic      idxClr;
    logic      idxInc;
    logic      storeRd;
    logic      storeCnt;
    byte_sel_e sel;
  } ctrl_strobe_t;

endpackage

// File: rtl/smbus_seq_dp.sv
module smbus_seq_dp
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int CW = $clog2(MAX_BLOCK + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strobe,
  input  logic [3:0]             reqProto,
  input  logic [6:0]             reqAddr,
  input  logic [7:0]             reqCmd,
  input  logic [15:0]            reqWord,
  input  logic [CW-1:0]          reqCount,
  input  logic [MAX_BLOCK*8-1:0] reqBlock,
  input  logic [7:0]             rxData,
  output logic [3:0]             protoQ,
  output logic                   reqBad,
  output logic                   wrLast,
  output logic                   rdLast,
  output logic                   cntBad,
  output logic [7:0]             opData,
  output logic [MAX_BLOCK*8-1:0] rdData,
  output logic [CW-1:0]          rdCount
);

  localparam int IW = $clog2(MAX_BLOCK);
  localparam logic [CW-1:0] CNT_FULL = CW'(MAX_BLOCK);
  localparam logic [CW-1:0] CNT_PROC = CW'(MAX_BLOCK - 1);

  logic [6:0]                  addrQ;
  logic [7:0]                  cmdQ;
  logic [15:0]                 wordQ;
  logic [CW-1:0]               countQ;
  logic [MAX_BLOCK-1:0][7:0]   blockQ;
  logic [MAX_BLOCK-1:0][7:0]   rdBuf;
  logic [CW-1:0]               idx;
  logic [CW-1:0]               rdLenQ;
  logic [CW-1:0]               wrLen;
  logic [CW-1:0]               rdLen;
  logic [7:0]                  cntLimit;
  logic [7:0]                  wrByte;
  logic                        firstRd;

  // request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protoQ <= '0;
      addrQ  <= '0;
      cmdQ   <= '0;
      wordQ  <= '0;
      countQ <= '0;
      blockQ <= '0;
    end else if (strobe.latch) begin
      protoQ <= reqProto;
      addrQ  <= reqAddr;
      cmdQ   <= reqCmd;
      wordQ  <= reqWord;
      countQ <= reqCount;
      blockQ <= reqBlock;
    end
  end

  // byte index within the current data phase, target count, result buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      rdLenQ  <= '0;
      rdCount <= '0;
      rdBuf   <= '0;
    end else begin
      if (strobe.idxClr)      idx <= '0;
      else if (strobe.idxInc) idx <= idx + CW'(1);
      if (strobe.storeCnt) rdLenQ <= rxData[CW-1:0];
      if (strobe.latch) rdCount <= '0;
      else if (strobe.storeRd) begin
        rdBuf[idx[IW-1:0]] <= rxData;
        rdCount            <= idx + CW'(1);
      end
    end
  end

  assign rdData = rdBuf;

  always_comb begin
    case (protoQ)
      P_WR_BYTE:         wrLen = CW'(1);
      P_WR_WORD, P_PROC: wrLen = CW'(2);
      default:           wrLen = countQ;
    endcase
    case (protoQ)
      P_RECV, P_RD_BYTE: rdLen = CW'(1);
      P_RD_WORD, P_PROC: rdLen = CW'(2);
      default:           rdLen = rdLenQ;
    endcase
  end

  assign wrLast   = (idx == wrLen - CW'(1));
  assign rdLast   = (idx == rdLen - CW'(1));
  assign cntLimit = (protoQ == P_BLK_PROC) ? 8'(MAX_BLOCK - 1) : 8'(MAX_BLOCK);
  assign cntBad   = (rxData == 8'd0) || (rxData > cntLimit);
  assign firstRd  = (protoQ == P_QUICK_R) || (protoQ == P_RECV);

  always_comb begin
    if (protoQ == P_BLK_WR || protoQ == P_BLK_PROC) wrByte = blockQ[idx[IW-1:0]];
    else if (idx == '0)                              wrByte = wordQ[7:0];
    else                                             wrByte = wordQ[15:8];
  end

  always_comb begin
    case (strobe.sel)
      SEL_ADDR_W: opData = {addrQ, firstRd};
      SEL_ADDR_R: opData = {addrQ, 1'b1};
      SEL_CMD:    opData = cmdQ;
      SEL_WCNT:   opData = 8'(countQ);
      SEL_WDATA:  opData = wrByte;
      default:    opData = 8'h00;
    endcase
  end

  // malformed request screening on the raw inputs
  always_comb begin
    reqBad = (reqProto > P_BLK_PROC);
    if (reqProto == P_BLK_WR && (reqCount == '0 || reqCount > CNT_FULL)) reqBad = 1'b1;
    if (reqProto == P_BLK_PROC && (reqCount == '0 || reqCount > CNT_PROC)) reqBad = 1'b1;
  end

endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqStart,
  input  logic         reqBad,
  input  logic [3:0]   protoQ,
  input  logic         opDone,
  input  logic         rxNack,
  input  logic         wrLast,
  input  logic         rdLast,
  input  logic         cntBad,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         opValid,
  output logic [2:0]   opCode,
  output logic         opNack,
  output logic         done,
  output logic         error,
  output logic [2:0]   errPhase
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDRW, ST_CMD, ST_WCNT, ST_WDATA,
    ST_RSTART, ST_ADDRR, ST_RCNT, ST_RDATA, ST_DRAIN, ST_STOP
  } state_e;

  state_e     state, stNext;
  logic       pendErr;
  logic [2:0] pendPhase;
  logic       setErr;
  logic [2:0] errCode;
  logic       isQuick, isRecv, hasWCnt, hasWData, hasRead, blkRead;

  assign isQuick  = (protoQ == P_QUICK_W) || (protoQ == P_QUICK_R);
  assign isRecv   = (protoQ == P_RECV);
  assign hasWCnt  = (protoQ == P_BLK_WR) || (protoQ == P_BLK_PROC);
  assign hasWData = hasWCnt || (protoQ == P_WR_BYTE) || (protoQ == P_WR_WORD) || (protoQ == P_PROC);
  assign blkRead  = (protoQ == P_BLK_RD) || (protoQ == P_BLK_PROC);
  assign hasRead  = blkRead || (protoQ == P_RD_BYTE) || (protoQ == P_RD_WORD) || (protoQ == P_PROC);

  assign busy    = (state != ST_IDLE);
  assign opValid = (state != ST_IDLE);

  always_comb begin
    stNext  = state;
    strobe  = '0;
    setErr  = 1'b0;
    errCode = ERR_NONE;
    opCode  = OP_STOP;
    opNack  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqStart && !reqBad) begin
          strobe.latch  = 1'b1;
          strobe.idxClr = 1'b1;
          stNext        = ST_START;
        end
      end
      ST_START: begin
        opCode = OP_START;
        if (opDone) stNext = ST_ADDRW;
      end
      ST_ADDRW: begin
        opCode     = OP_WRITE;
        strobe.sel = SEL_ADDR_W;
        if (opDone) begin
          if (rxNack) begin setErr = 1'b1; errCode = ERR_ADDR; stNext = ST_STOP; end
          else if (isQuick) stNext = ST_STOP;
          else if (isRecv)  stNext = ST_RDATA;
          else              stNext = ST_CMD;
        end
      end
      ST_CMD: begin
        opCode     = OP_WRITE;
        strobe.sel = SEL_CMD;
        if (opDone) begin
          if (rxNack) begin setErr = 1'b1; errCode = ERR_CMD; stNext = ST_STOP; end
          else if (hasWCnt)  stNext = ST_WCNT;
          else if (hasWData) stNext = ST_WDATA;
          else if (hasRead)  stNext = ST_RSTART;
          else               stNext = ST_STOP;
        end
      end
      ST_WCNT: begin
        opCode     = OP_WRITE;
        strobe.sel = SEL_WCNT;
        if (opDone) begin
          if (rxNack) begin setErr = 1'b1; errCode = ERR_DATA; stNext = ST_STOP; end
          else stNext = ST_WDATA;
        end
      end
      ST_WDATA: begin
        opCode     = OP_WRITE;
        strobe.sel = SEL_WDATA;
        if (opDone) begin
          if (rxNack) begin setErr = 1'b1; errCode = ERR_DATA; stNext = ST_STOP; end
          else if (wrLast) stNext = hasRead ? ST_RSTART : ST_STOP;
          else strobe.idxInc = 1'b1;
        end
      end
      ST_RSTART: begin
        opCode = OP_RSTART;
        if (opDone) stNext = ST_ADDRR;
      end
      ST_ADDRR: begin
        opCode     = OP_WRITE;
        strobe.sel = SEL_ADDR_R;
        if (opDone) begin
          if (rxNack) begin setErr = 1'b1; errCode = ERR_RADDR; stNext = ST_STOP; end
          else stNext = blkRead ? ST_RCNT : ST_RDATA;
        end
      end
      ST_RCNT: begin
        opCode = OP_READ;
        if (opDone) begin
          if (cntBad) begin setErr = 1'b1; errCode = ERR_COUNT; stNext = ST_DRAIN; end
          else begin strobe.storeCnt = 1'b1; stNext = ST_RDATA; end
        end
      end
      ST_RDATA: begin
        opCode = OP_READ;
        opNack = rdLast;
        if (opDone) begin
          strobe.storeRd = 1'b1;
          if (rdLast) stNext = ST_STOP;
          else        strobe.idxInc = 1'b1;
        end
      end
      ST_DRAIN: begin
        opCode = OP_READ;
        opNack = 1'b1;
        if (opDone) stNext = ST_STOP;
      end
      ST_STOP: begin
        opCode = OP_STOP;
        if (opDone) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
    if (opDone && state != ST_IDLE && state != ST_WDATA && state != ST_RDATA)
      strobe.idxClr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendErr   <= 1'b0;
      pendPhase <= ERR_NONE;
      done      <= 1'b0;
      error     <= 1'b0;
      errPhase  <= ERR_NONE;
    end else begin
      state <= stNext;
      done  <= 1'b0;
      if (state == ST_IDLE && reqStart) begin
        pendErr   <= 1'b0;
        pendPhase <= ERR_NONE;
        if (reqBad) begin
          done     <= 1'b1;
          error    <= 1'b1;
          errPhase <= ERR_REQ;
        end
      end
      if (setErr) begin
        pendErr   <= 1'b1;
        pendPhase <= errCode;
      end
      if (state == ST_STOP && opDone) begin
        done     <= 1'b1;
        error    <= pendErr;
        errPhase <= pendPhase;
      end
    end
  end

endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int CW = $clog2(MAX_BLOCK + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqStart,
  input  logic [3:0]             reqProto,
  input  logic [6:0]             reqAddr,
  input  logic [7:0]             reqCmd,
  input  logic [15:0]            reqWord,
  input  logic [CW-1:0]          reqCount,
  input  logic [MAX_BLOCK*8-1:0] reqBlock,
  output logic                   busy,
  output logic                   opValid,
  output logic [2:0]             opCode,
  output logic [7:0]             opData,
  output logic                   opNack,
  input  logic                   opDone,
  input  logic                   rxNack,
  input  logic [7:0]             rxData,
  output logic                   done,
  output logic                   error,
  output logic [2:0]             errPhase,
  output logic [MAX_BLOCK*8-1:0] rdData,
  output logic [CW-1:0]          rdCount
);

  ctrl_strobe_t strobe;
  logic [3:0]   protoQ;
  logic         reqBad, wrLast, rdLast, cntBad;

  smbus_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqStart (reqStart),
    .reqBad   (reqBad),
    .protoQ   (protoQ),
    .opDone   (opDone),
    .rxNack   (rxNack),
    .wrLast   (wrLast),
    .rdLast   (rdLast),
    .cntBad   (cntBad),
    .strobe   (strobe),
    .busy     (busy),
    .opValid  (opValid),
    .opCode   (opCode),
    .opNack   (opNack),
    .done     (done),
    .error    (error),
    .errPhase (errPhase)
  );

  smbus_seq_dp #(.MAX_BLOCK(MAX_BLOCK), .CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqProto (reqProto),
    .reqAddr  (reqAddr),
    .reqCmd   (reqCmd),
    .reqWord  (reqWord),
    .reqCount (reqCount),
    .reqBlock (reqBlock),
    .rxData   (rxData),
    .protoQ   (protoQ),
    .reqBad   (reqBad),
    .wrLast   (wrLast),
    .rdLast   (rdLast),
    .cntBad   (cntBad),
    .opData   (opData),
    .rdData   (rdData),
    .rdCount  (rdCount)
  );

endmodule

// File: rtl/smbus_txn_seq_chk.sv
module smbus_txn_seq_chk
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int CW = $clog2(MAX_BLOCK + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          opValid,
  input logic [2:0]    opCode,
  input logic [7:0]    opData,
  input logic          opNack,
  input logic          opDone,
  input logic          rxNack,
  input logic          done,
  input logic          error,
  input logic [CW-1:0] rdCount
);

  p_hold_op_r14: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !opDone |=> opValid && $stable(opCode) && $stable(opData) && $stable(opNack));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !opValid);

  p_nack_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opDone && opCode == OP_WRITE && rxNack |=> opValid && opCode == OP_STOP);

  p_last_read_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opDone && opCode == OP_READ && opNack |=> opValid && opCode == OP_STOP);

  p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(error) |-> done);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdCount <= CW'(MAX_BLOCK));

endmodule

bind smbus_txn_seq smbus_txn_seq_chk #(.MAX_BLOCK(MAX_BLOCK), .CW(CW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .opValid (opValid),
  .opCode  (opCode),
  .opData  (opData),
  .opNack  (opNack),
  .opDone  (opDone),
  .rxNack  (rxNack),
  .done    (done),
  .error   (error),
  .rdCount (rdCount)
);

// File: tb/smbus_txn_seq_tb.sv
`timescale 1ns/1ps
module smbus_txn_seq_tb;

  localparam int MAXB = 32;
  localparam int CW   = 6;

  logic            clk = 1'b0;
  logic            rstN;
  logic            reqStart;
  logic [3:0]      reqProto;
  logic [6:0]      reqAddr;
  logic [7:0]      reqCmd;
  logic [15:0]     reqWord;
  logic [CW-1:0]   reqCount;
  logic [MAXB*8-1:0] reqBlock;
  logic            busy, opValid, opNack, done, error;
  logic [2:0]      opCode, errPhase;
  logic [7:0]      opData;
  logic            opDone, rxNack;
  logic [7:0]      rxData;
  logic [MAXB*8-1:0] rdData;
  logic [CW-1:0]   rdCount;

  always #2.5 clk = ~clk;

  smbus_txn_seq #(.MAX_BLOCK(MAXB)) u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqProto(reqProto),
    .reqAddr(reqAddr), .reqCmd(reqCmd), .reqWord(reqWord), .reqCount(reqCount),
    .reqBlock(reqBlock), .busy(busy), .opValid(opValid), .opCode(opCode),
    .opData(opData), .opNack(opNack), .opDone(opDone), .rxNack(rxNack),
    .rxData(rxData), .done(done), .error(error), .errPhase(errPhase),
    .rdData(rdData), .rdCount(rdCount)
  );

  typedef struct packed {
    logic [2:0] code;
    logic [7:0] data;
    logic       nack;
  } op_t;

  op_t        expQ[$];
  logic [7:0] readQ[$];
  int         nackAt = -1;
  int         wrSeen = 0;
  int         checks = 0;
  int         errors = 0;
  string      curReq = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic eS();           expQ.push_back('{3'd0, 8'h00, 1'b0}); endtask
  task automatic eRS();          expQ.push_back('{3'd1, 8'h00, 1'b0}); endtask
  task automatic eW(input logic [7:0] d); expQ.push_back('{3'd2, d, 1'b0}); endtask
  task automatic eR(input logic n);       expQ.push_back('{3'd3, 8'h00, n}); endtask
  task automatic eP();           expQ.push_back('{3'd4, 8'h00, 1'b0}); endtask

  // engine model and scoreboard monitor
  initial begin
    opDone = 1'b0;
    rxNack = 1'b0;
    rxData = 8'h00;
    forever begin
      @(negedge clk);
      if (rstN && opValid) begin
        op_t  e;
        logic nk;
        nk = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, curReq, "unexpected op", longint'(opCode), 0);
        end else begin
          e = expQ.pop_front();
          check(opCode == e.code, curReq, "op code", longint'(opCode), longint'(e.code));
          if (e.code == 3'd2)
            check(opData == e.data, curReq, "write byte", longint'(opData), longint'(e.data));
          if (e.code == 3'd3)
            check(opNack == e.nack, curReq, "read nack", longint'(opNack), longint'(e.nack));
        end
        if (opCode == 3'd2) begin
          nk = (wrSeen == nackAt);
          wrSeen++;
        end
        if (opCode == 3'd3) rxData = (readQ.size() != 0) ? readQ.pop_front() : 8'h00;
        repeat (2) @(negedge clk);
        rxNack = nk;
        opDone = 1'b1;
        @(negedge clk);
        opDone = 1'b0;
        rxNack = 1'b0;
      end
    end
  end

  task automatic issue(input logic [3:0] p, input logic [6:0] a, input logic [7:0] c,
                       input logic [15:0] w, input logic [CW-1:0] n, input logic [MAXB*8-1:0] b);
    @(negedge clk);
    reqProto = p; reqAddr = a; reqCmd = c; reqWord = w; reqCount = n; reqBlock = b;
    wrSeen = 0;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic finish(input string req, input logic e, input logic [2:0] ph);
    check(expQ.size() == 0, req, "ops left", expQ.size(), 0);
    check(error == e, req, "error", longint'(error), longint'(e));
    check(errPhase == ph, req, "errPhase", longint'(errPhase), longint'(ph));
    expQ.delete();
    readQ.delete();
    nackAt = -1;
  endtask

  initial begin
    logic [MAXB*8-1:0] blk;
    rstN = 1'b0; reqStart = 1'b0; reqProto = '0; reqAddr = '0; reqCmd = '0;
    reqWord = '0; reqCount = '0; reqBlock = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R13)
    check(busy == 1'b0 && opValid == 1'b0, "R13", "reset busy/opValid", {busy, opValid}, 0);
    check(done == 1'b0 && error == 1'b0 && rdCount == 0, "R13", "reset outputs", {done, error}, 0);

    // R2/R1 quick write then quick read
    curReq = "R2"; eS(); eW(8'h54); eP();
    issue(4'd0, 7'h2A, 8'h00, 16'h0, 6'd0, '0);
    waitDone(); finish("R2", 1'b0, 3'd0);
    @(negedge clk);
    check(done == 1'b0, "R13", "done width", longint'(done), 0);
    curReq = "R1"; eS(); eW(8'h55); eP();
    issue(4'd1, 7'h2A, 8'h00, 16'h0, 6'd0, '0);
    waitDone(); finish("R1", 1'b0, 3'd0);

    // R3 send byte, receive byte
    curReq = "R3"; eS(); eW(8'h78); eW(8'hA5); eP();
    issue(4'd2, 7'h3C, 8'hA5, 16'h0, 6'd0, '0);
    waitDone(); finish("R3", 1'b0, 3'd0);
    eS(); eW(8'h79); eR(1'b1); eP(); readQ.push_back(8'h5E);
    issue(4'd3, 7'h3C, 8'h00, 16'h0, 6'd0, '0);
    waitDone();
    check(rdCount == 1 && rdData[7:0] == 8'h5E, "R3", "recv data", rdData[7:0], 8'h5E);
    finish("R3", 1'b0, 3'd0);

    // R5 write byte, write word
    curReq = "R5"; eS(); eW(8'h20); eW(8'h07); eW(8'hEF); eP();
    issue(4'd4, 7'h10, 8'h07, 16'hBEEF, 6'd0, '0);
    waitDone(); finish("R5", 1'b0, 3'd0);
    eS(); eW(8'h20); eW(8'h07); eW(8'hEF); eW(8'hBE); eP();
    issue(4'd6, 7'h10, 8'h07, 16'hBEEF, 6'd0, '0);
    waitDone(); finish("R5", 1'b0, 3'd0);

    // R4 read byte, read word
    curReq = "R4"; eS(); eW(8'h20); eW(8'h09); eRS(); eW(8'h21); eR(1'b1); eP();
    readQ.push_back(8'hC3);
    issue(4'd5, 7'h10, 8'h09, 16'h0, 6'd0, '0);
    waitDone();
    check(rdCount == 1 && rdData[7:0] == 8'hC3, "R4", "read byte", rdData[7:0], 8'hC3);
    finish("R4", 1'b0, 3'd0);
    eS(); eW(8'h20); eW(8'h07); eRS(); eW(8'h21); eR(1'b0); eR(1'b1); eP();
    readQ.push_back(8'h34); readQ.push_back(8'h12);
    issue(4'd7, 7'h10, 8'h07, 16'h0, 6'd0, '0);
    waitDone();
    check(rdCount == 2 && rdData[15:0] == 16'h1234, "R4", "read word", rdData[15:0], 16'h1234);
    finish("R4", 1'b0, 3'd0);

    // R6 process call
    curReq = "R6"; eS(); eW(8'hE0); eW(8'h55); eW(8'h02); eW(8'h01); eRS(); eW(8'hE1);
    eR(1'b0); eR(1'b1); eP();
    readQ.push_back(8'hAA); readQ.push_back(8'hBB);
    issue(4'd8, 7'h70, 8'h55, 16'h0102, 6'd0, '0);
    waitDone();
    check(rdData[15:0] == 16'hBBAA, "R6", "proc result", rdData[15:0], 16'hBBAA);
    finish("R6", 1'b0, 3'd0);

    // R7 block write of 3
    curReq = "R7"; blk = '0; blk[7:0] = 8'h11; blk[15:8] = 8'h22; blk[23:16] = 8'h33;
    eS(); eW(8'h40); eW(8'h5A); eW(8'h03); eW(8'h11); eW(8'h22); eW(8'h33); eP();
    issue(4'd9, 7'h20, 8'h5A, 16'h0, 6'd3, blk);
    waitDone(); finish("R7", 1'b0, 3'd0);

    // R8 block read of 4 and of the full 32
    curReq = "R8"; eS(); eW(8'h40); eW(8'h66); eRS(); eW(8'h41); eR(1'b0);
    readQ.push_back(8'd4);
    for (int i = 0; i < 4; i++) begin eR(i == 3); readQ.push_back(8'(8'h90 + i)); end
    eP();
    issue(4'd10, 7'h20, 8'h66, 16'h0, 6'd0, '0);
    waitDone();
    check(rdCount == 4, "R8", "count 4", rdCount, 4);
    check(rdData[31:0] == 32'h93929190, "R8", "block bytes", rdData[31:0], 32'h93929190);
    finish("R8", 1'b0, 3'd0);
    eS(); eW(8'h40); eW(8'h66); eRS(); eW(8'h41); eR(1'b0); readQ.push_back(8'd32);
    for (int i = 0; i < 32; i++) begin eR(i == 31); readQ.push_back(8'(i * 3)); end
    eP();
    issue(4'd10, 7'h20, 8'h66, 16'h0, 6'd0, '0);
    waitDone();
    check(rdCount == 32, "R8", "count 32", rdCount, 32);
    check(rdData[255:248] == 8'd93, "R8", "last byte", rdData[255:248], 93);
    finish("R8", 1'b0, 3'd0);

    // R9 block process call, write 2, read 31
    curReq = "R9"; blk = '0; blk[7:0] = 8'hA1; blk[15:8] = 8'hA2;
    eS(); eW(8'h40); eW(8'h77); eW(8'h02); eW(8'hA1); eW(8'hA2); eRS(); eW(8'h41); eR(1'b0);
    readQ.push_back(8'd31);
    for (int i = 0; i < 31; i++) begin eR(i == 30); readQ.push_back(8'(8'h40 + i)); end
    eP();
    issue(4'd11, 7'h20, 8'h77, 16'h0, 6'd2, blk);
    waitDone();
    check(rdCount == 31 && rdData[247:240] == 8'h5E, "R9", "proc block", rdData[247:240], 8'h5E);
    finish("R9", 1'b0, 3'd0);

    // R11 bad returned count: 32 in process call, 0 in block read
    curReq = "R11";
    eS(); eW(8'h40); eW(8'h77); eW(8'h01); eW(8'hA1); eRS(); eW(8'h41); eR(1'b0); eR(1'b1); eP();
    readQ.push_back(8'd32);
    issue(4'd11, 7'h20, 8'h77, 16'h0, 6'd1, blk);
    waitDone();
    check(rdCount == 0, "R11", "rdCount after bad count", rdCount, 0);
    finish("R11", 1'b1, 3'd5);
    eS(); eW(8'h40); eW(8'h66); eRS(); eW(8'h41); eR(1'b0); eR(1'b1); eP();
    readQ.push_back(8'd0);
    issue(4'd10, 7'h20, 8'h66, 16'h0, 6'd0, '0);
    waitDone(); finish("R11", 1'b1, 3'd5);

    // R10 nacks: first address, second word byte, read address
    curReq = "R10"; nackAt = 0; eS(); eW(8'h24); eP();
    issue(4'd6, 7'h12, 8'h01, 16'h0, 6'd0, '0);
    waitDone(); finish("R10", 1'b1, 3'd1);
    nackAt = 3; eS(); eW(8'h24); eW(8'h01); eW(8'hCD); eW(8'hAB); eP();
    issue(4'd6, 7'h12, 8'h01, 16'hABCD, 6'd0, '0);
    waitDone(); finish("R10", 1'b1, 3'd3);
    nackAt = 2; eS(); eW(8'h24); eW(8'h01); eRS(); eW(8'h25); eP();
    issue(4'd5, 7'h12, 8'h01, 16'h0, 6'd0, '0);
    waitDone(); finish("R10", 1'b1, 3'd4);

    // R12 malformed requests
    curReq = "R12";
    issue(4'd13, 7'h12, 8'h01, 16'h0, 6'd0, '0);
    waitDone(); finish("R12", 1'b1, 3'd6);
    issue(4'd9, 7'h12, 8'h01, 16'h0, 6'd0, '0);
    waitDone(); finish("R12", 1'b1, 3'd6);
    issue(4'd11, 7'h12, 8'h01, 16'h0, 6'd32, '0);
    waitDone(); finish("R12", 1'b1, 3'd6);

    // R13 start while busy is ignored
    curReq = "R13"; eS(); eW(8'h20); eW(8'h07); eW(8'h11); eW(8'h22); eP();
    issue(4'd6, 7'h10, 8'h07, 16'h2211, 6'd0, '0);
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R13", "busy mid txn", longint'(busy), 1);
    reqProto = 4'd0; reqAddr = 7'h7F; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    waitDone(); finish("R13", 1'b0, 3'd0);
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && opValid == 1'b0, "R13", "idle after done", {busy, opValid}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule